// File: doc/BRIEF.md
# Bit-Serial Disk Transfer Engine

This block moves data one bit at a time between a rotating magnetic disk and a host processor. A drive sequencer outside the block produces a bit strobe at the rate the medium passes under the head. On each accepted strobe the engine handles one bit cell at the current head position and then moves the head forward by one cell. In read mode it first hunts for the end of the inter-record gap, which is the first 1 bit after a run of zeros. It then gathers bytes least significant bit first and hands each complete byte to the host. In write mode it emits zeros until a transfer is armed. After that it shifts out a byte taken from a separate write latch and reloads from that latch every eight cells.

The host talks to the engine through four byte-wide registers: a write latch, a control register, a status register and a read-data register. The engine raises an interrupt when a byte boundary is reached and interrupts are enabled. There is also a skip mode in which the head keeps moving but no cell is touched, and a write-protected disk is never modified.

The disk side is a one-bit port addressed by head position. A read returns its bit one cycle after the request. The port has no back-pressure: the disk model must accept every request in the cycle it is issued. The sequencer keeps strobes at least four clock cycles apart. A strobe that arrives while a previous bit is still being handled, or when the head sits at the end of the disk, is dropped.

Top module: `disk_xfer_engine`

## Requirements
- R1: After reset the head position is 0, the interrupt output is low, the transfer flag is clear, skip mode is off and status reads 0x00 when the disk is write-protected.
- R2: Every accepted strobe moves the head forward by exactly one, in every mode. The head stops at DISK_BYTES*8, where `at_end` and status bit 6 go high. Further strobes are dropped. A `head_home` pulse returns the head to 0.
- R3: The disk port address equals the head position: byte index = address >> 3, bit = address & 7, so bytes are stored LSB first. Read data is taken one cycle after `dsk_rd_en`. Read and write requests never occur together.
- R4: A write to the control register (address 1) that takes bit 6 from 0 to 1 arms the gap search. In read mode (control bit 2 = 1) with control bit 4 clear, armed cells holding 0 are skipped. The first 1 ends the search and is not part of any byte.
- R5: In read mode, after eight data cells the byte (first cell in bit 0) appears in the read-data register (address 3). The transfer flag (status bit 1) is set, and `irq` rises if control bit 7 is set.
- R6: Control bit 4 (check phase) suspends the gap search. It clears itself when the next byte completes, so an armed engine resumes searching for a gap after that byte.
- R7: In write mode (control bit 2 = 0) an unarmed engine writes 0 to every cell. The arming edge loads the shifter from the write latch (address 0), restarts the bit count and sets the transfer flag.
- R8: An armed writer emits the shifter LSB first. After eight cells it reloads from the write latch, sets the transfer flag and raises `irq` if control bit 7 is set.
- R9: When a written byte completes with control bit 4 set, bit 4 is cleared and the write latch is zeroed after being copied to the shifter.
- R10: With `write_protect` high (or no disk present) a write-mode strobe issues no `dsk_wr_en`, and the head still advances.
- R11: A control write with bit 1 set turns on skip mode, shown on `xfer_reset`. In skip mode strobes advance the head with no disk access. Skip mode stays on until `head_home`.
- R12: Reading status (address 2) clears the transfer flag and `irq`. Reading read-data or writing the write latch clears only the flag. Any control write clears only `irq`. Status bit 7 = `disk_present` and not `write_protect`.
- R13: A control write with bit 0 set produces a one-cycle `motor_go` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_strobe | input | 1 | One bit cell is due at the head |
| head_home | input | 1 | Head returned to start; also ends skip mode |
| disk_present | input | 1 | A disk is in the drive |
| write_protect | input | 1 | Disk must not be written |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the edge) |
| reg_addr | input | 2 | 0 write latch, 1 control, 2 status, 3 read data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Byte interrupt |
| motor_go | output | 1 | Motor start request pulse |
| xfer_reset | output | 1 | Skip mode active |
| head_pos | output | POS_W | Current head position in bits |
| at_end | output | 1 | Head at the end of the disk |
| dsk_rd_en | output | 1 | Read request for the bit at `dsk_addr` |
| dsk_wr_en | output | 1 | Write `dsk_wdata` to the bit at `dsk_addr` |
| dsk_addr | output | POS_W | Bit address on the disk |
| dsk_wdata | output | 1 | Bit to write |
| dsk_rdata | input | 1 | Bit read, valid one cycle after `dsk_rd_en` |

## Verification
A wrong bit counter or a missed gap end never fails quietly. It shifts every later byte by a whole number of cells, so the next value in the read-data register, or the next byte on the disk, comes out rotated, and the flag rises on the wrong strobe, no more than eight strobes after the fault. A check-phase bit that fails to clear shows up one byte later: the flag fires eight strobes early inside what should be a gap. A head that skips or stalls shifts every following disk address and moves the end-of-disk status to a different strobe count.

// File: rtl/disk_xfer_pkg.sv
`timescale 1ns/1ps
package disk_xfer_pkg;

  // register addresses seen by the host
  localparam logic [1:0] ADDR_WLATCH = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_RDATA  = 2'd3;

  // control register bit positions
  localparam int CB_MOTOR = 0;
  localparam int CB_SKIP  = 1;
  localparam int CB_READ  = 2;
  localparam int CB_CHECK = 4;
  localparam int CB_ARM   = 6;
  localparam int CB_IRQEN = 7;

  // status register bit positions
  localparam int SB_FLAG     = 1;
  localparam int SB_END      = 6;
  localparam int SB_WRITABLE = 7;

  // what one accepted strobe will do to its cell
  typedef enum logic [1:0] {
    OP_SKIP  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } bit_op_e;

endpackage

// File: rtl/disk_xfer_head.sv
`timescale 1ns/1ps
module disk_xfer_head
  import disk_xfer_pkg::*;
#(
  parameter int DISK_BITS = 65500 * 8,
  localparam int POS_W = $clog2(DISK_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_strobe,
  input  logic             head_home,
  input  bit_op_e          op_in,
  output logic             accept,
  output logic             proc,
  output bit_op_e          proc_op,
  output logic [POS_W-1:0] head_pos,
  output logic             at_end
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(DISK_BITS);

  logic [POS_W-1:0] pos_q;
  logic             proc_q;
  bit_op_e          op_q;

  assign at_end = (pos_q == LAST_POS);
  // one strobe in flight at a time; none at the end or while homing
  assign accept = bit_strobe && !proc_q && !at_end && !head_home;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      proc_q <= 1'b0;
      op_q   <= OP_SKIP;
    end else begin
      proc_q <= accept;
      if (accept) op_q <= op_in;
      if (head_home) pos_q <= '0;
      else if (proc_q && !at_end) pos_q <= pos_q + POS_W'(1);
    end
  end

  assign proc     = proc_q;
  assign proc_op  = op_q;
  assign head_pos = pos_q;

endmodule

// File: rtl/disk_xfer_shift.sv
`timescale 1ns/1ps
module disk_xfer_shift
  import disk_xfer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc,
  input  bit_op_e           proc_op,
  input  logic              rd_bit,
  input  logic              arm_edge,
  input  logic              wr_load,
  input  logic [BYTE_W-1:0] wlatch,
  input  logic              check_on,
  output logic              wr_en,
  output logic              wr_bit,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rlatch
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic              armed_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rsh_q, rsh_nxt;
  logic [BYTE_W-1:0] wsh_q;
  logic [BYTE_W-1:0] rlatch_q;

  logic do_read, do_write, gap_mode, gap_hit, rd_data, wr_data, step;

  assign do_read  = proc && (proc_op == OP_READ);
  assign do_write = proc && (proc_op == OP_WRITE);
  assign gap_mode = armed_q && !check_on;
  assign gap_hit  = do_read && gap_mode && rd_bit;
  assign rd_data  = do_read && !gap_mode;
  assign wr_data  = do_write && armed_q;
  assign step     = rd_data || wr_data;
  assign byte_done = step && (cnt_q == CNT_LAST);

  assign wr_en  = do_write;
  assign wr_bit = wr_data ? wsh_q[cnt_q] : 1'b0;

  always_comb begin
    rsh_nxt = rsh_q;
    rsh_nxt[cnt_q] = rd_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      rsh_q    <= '0;
      wsh_q    <= '0;
      rlatch_q <= '0;
    end else begin
      if (arm_edge)     armed_q <= 1'b1;
      else if (gap_hit) armed_q <= 1'b0;

      if (wr_load || gap_hit) cnt_q <= '0;
      else if (step)          cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);

      if (rd_data) rsh_q <= rsh_nxt;
      if (rd_data && cnt_q == CNT_LAST) rlatch_q <= rsh_nxt;

      if (wr_load) wsh_q <= wlatch;
      else if (wr_data && cnt_q == CNT_LAST) wsh_q <= wlatch;
    end
  end

  assign rlatch = rlatch_q;

endmodule

// File: rtl/disk_xfer_regs.sv
`timescale 1ns/1ps
module disk_xfer_regs
  import disk_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       disk_present,
  input  logic       write_protect,
  input  logic       at_end,
  input  logic       head_home,
  input  logic       byte_done,
  input  logic       byte_is_write,
  input  logic [7:0] rlatch,
  output logic [7:0] ctrl,
  output logic [7:0] wlatch,
  output logic       arm_edge,
  output logic       wr_load,
  output logic       irq,
  output logic       motor_go,
  output logic       xfer_reset
);

  logic [7:0] ctrl_q, wlatch_q;
  logic       flag_q, irq_q, motor_q, skip_q;
  logic       wr_ctrl, wr_latch, rd_stat, rd_data, check_done;
  logic [7:0] status;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_latch = reg_wr && (reg_addr == ADDR_WLATCH);
  assign rd_stat  = reg_rd && (reg_addr == ADDR_STATUS);
  assign rd_data  = reg_rd && (reg_addr == ADDR_RDATA);

  assign arm_edge   = wr_ctrl && !ctrl_q[CB_ARM] && reg_wdata[CB_ARM];
  assign wr_load    = arm_edge && !reg_wdata[CB_READ];
  assign check_done = byte_done && ctrl_q[CB_CHECK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      wlatch_q <= '0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      motor_q  <= 1'b0;
      skip_q   <= 1'b0;
    end else begin
      if (wr_ctrl)         ctrl_q <= reg_wdata;
      else if (check_done) ctrl_q[CB_CHECK] <= 1'b0;

      if (wr_latch)                        wlatch_q <= reg_wdata;
      else if (check_done && byte_is_write) wlatch_q <= '0;

      // engine events win over host clears so no byte is lost
      if (byte_done || wr_load)               flag_q <= 1'b1;
      else if (rd_stat || rd_data || wr_latch) flag_q <= 1'b0;

      if (byte_done && ctrl_q[CB_IRQEN]) irq_q <= 1'b1;
      else if (rd_stat || wr_ctrl)       irq_q <= 1'b0;

      motor_q <= wr_ctrl && reg_wdata[CB_MOTOR];

      if (head_home)                           skip_q <= 1'b0;
      else if (wr_ctrl && reg_wdata[CB_SKIP])  skip_q <= 1'b1;
    end
  end

  always_comb begin
    status = '0;
    status[SB_FLAG]     = flag_q;
    status[SB_END]      = at_end;
    status[SB_WRITABLE] = disk_present && !write_protect;
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_STATUS: reg_rdata = status;
      ADDR_RDATA:  reg_rdata = rlatch;
      default:     reg_rdata = '0;
    endcase
  end

  assign ctrl       = ctrl_q;
  assign wlatch     = wlatch_q;
  assign irq        = irq_q;
  assign motor_go   = motor_q;
  assign xfer_reset = skip_q;

endmodule

// File: rtl/disk_xfer_engine.sv
`timescale 1ns/1ps
module disk_xfer_engine
  import disk_xfer_pkg::*;
#(
  parameter int DISK_BYTES = 65500,
  localparam int DISK_BITS = DISK_BYTES * 8,
  localparam int POS_W = $clog2(DISK_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_strobe,
  input  logic             head_home,
  input  logic             disk_present,
  input  logic             write_protect,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq,
  output logic             motor_go,
  output logic             xfer_reset,
  output logic [POS_W-1:0] head_pos,
  output logic             at_end,
  output logic             dsk_rd_en,
  output logic             dsk_wr_en,
  output logic [POS_W-1:0] dsk_addr,
  output logic             dsk_wdata,
  input  logic             dsk_rdata
);

  bit_op_e    op_in, proc_op;
  logic       accept, proc, byte_done, arm_edge, wr_load;
  logic [7:0] ctrl, wlatch, rlatch;

  // the cell's operation is fixed when the strobe is taken
  always_comb begin
    if (xfer_reset)                         op_in = OP_SKIP;
    else if (ctrl[CB_READ])                 op_in = OP_READ;
    else if (write_protect || !disk_present) op_in = OP_SKIP;
    else                                    op_in = OP_WRITE;
  end

  assign dsk_rd_en = accept && (op_in == OP_READ);
  assign dsk_addr  = head_pos;

  disk_xfer_head #(.DISK_BITS(DISK_BITS)) u_head (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .head_home(head_home),
    .op_in(op_in), .accept(accept), .proc(proc), .proc_op(proc_op),
    .head_pos(head_pos), .at_end(at_end)
  );

  disk_xfer_shift #(.BYTE_W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .proc(proc), .proc_op(proc_op),
    .rd_bit(dsk_rdata), .arm_edge(arm_edge), .wr_load(wr_load),
    .wlatch(wlatch), .check_on(ctrl[CB_CHECK]),
    .wr_en(dsk_wr_en), .wr_bit(dsk_wdata), .byte_done(byte_done),
    .rlatch(rlatch)
  );

  disk_xfer_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .disk_present(disk_present), .write_protect(write_protect),
    .at_end(at_end), .head_home(head_home), .byte_done(byte_done),
    .byte_is_write(proc_op == OP_WRITE), .rlatch(rlatch),
    .ctrl(ctrl), .wlatch(wlatch), .arm_edge(arm_edge), .wr_load(wr_load),
    .irq(irq), .motor_go(motor_go), .xfer_reset(xfer_reset)
  );

endmodule

// File: rtl/disk_xfer_checker.sv
`timescale 1ns/1ps
module disk_xfer_checker #(
  parameter int DISK_BITS = 65500 * 8,
  localparam int POS_W = $clog2(DISK_BITS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             head_home,
  input logic             write_protect,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [1:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             irq,
  input logic             motor_go,
  input logic             xfer_reset,
  input logic [POS_W-1:0] head_pos,
  input logic             dsk_rd_en,
  input logic             dsk_wr_en,
  input logic             proc,
  input logic             byte_done
);

  // R2: a handled strobe moves the head by exactly one
  a_r2_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    (proc && !head_home) |=> (head_pos == $past(head_pos) + POS_W'(1)));

  // R2: the head never passes the end of the disk
  a_r2_head_bound: assert property (@(posedge clk) disable iff (!rst_n)
    head_pos <= POS_W'(DISK_BITS));

  // R3: one disk access per cycle at most
  a_r3_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(dsk_rd_en && dsk_wr_en));

  // R10: no write is issued for a strobe taken while protected
  a_r10_protect: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_wr_en |-> !$past(write_protect));

  // R11: skip mode never reads the disk
  a_r11_skip_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_reset |-> !dsk_rd_en);

  // R5: interrupt only rises after a completed byte
  a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(byte_done));

  // R12: a status read with no byte completing drops the interrupt
  a_r12_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2 && !byte_done) |=> !irq);

  // R13: motor pulse follows a control write carrying bit 0
  a_r13_motor_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    motor_go |-> $past(reg_wr && reg_addr == 2'd1 && reg_wdata[0]));

endmodule

bind disk_xfer_engine disk_xfer_checker #(.DISK_BITS(DISK_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .head_home(head_home), .write_protect(write_protect),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq(irq), .motor_go(motor_go), .xfer_reset(xfer_reset), .head_pos(head_pos),
  .dsk_rd_en(dsk_rd_en), .dsk_wr_en(dsk_wr_en), .proc(proc), .byte_done(byte_done)
);

// File: tb/test_disk_xfer_engine.sv
`timescale 1ns/1ps
module test_disk_xfer_engine;

  localparam int NBYTES = 64;
  localparam int NBITS  = NBYTES * 8;
  localparam int PW     = $clog2(NBITS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_strobe = 1'b0, head_home = 1'b0;
  logic disk_present = 1'b1, write_protect = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic irq, motor_go, xfer_reset, at_end, dsk_rd_en, dsk_wr_en, dsk_wdata;
  logic dsk_rdata = 1'b0;
  logic [PW-1:0] head_pos, dsk_addr;

  logic [7:0] mem [NBYTES];
  int n_chk = 0, n_bad = 0, n_rd = 0, n_wr = 0, n_motor = 0;
  bit done = 0;

  always #2 clk = ~clk;

  disk_xfer_engine #(.DISK_BYTES(NBYTES)) i_disk_xfer_engine (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .head_home(head_home),
    .disk_present(disk_present), .write_protect(write_protect),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .motor_go(motor_go), .xfer_reset(xfer_reset),
    .head_pos(head_pos), .at_end(at_end), .dsk_rd_en(dsk_rd_en), .dsk_wr_en(dsk_wr_en),
    .dsk_addr(dsk_addr), .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata)
  );

  // disk model: one-cycle read latency, bit-level write
  always @(posedge clk) begin
    if (dsk_rd_en) begin dsk_rdata <= mem[dsk_addr[PW-1:3]][dsk_addr[2:0]]; n_rd++; end
    if (dsk_wr_en) begin mem[dsk_addr[PW-1:3]][dsk_addr[2:0]] <= dsk_wdata; n_wr++; end
    if (motor_go) n_motor++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_strobe = 1'b1;
      @(negedge clk); bit_strobe = 1'b0;
      @(negedge clk); @(negedge clk);
    end
  endtask

  task automatic go_home;
    @(negedge clk); head_home = 1'b1;
    @(negedge clk); head_home = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int rd0, wr0;
    for (int i = 0; i < NBYTES; i++) mem[i] = 8'h00;
    mem[4] = 8'h80; mem[5] = 8'hA5; mem[6] = 8'h3C; mem[7] = 8'h01;
    mem[8] = 8'h5A; mem[9] = 8'h00; mem[10] = 8'h80; mem[11] = 8'h96;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 head", int'(head_pos), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 xfer_reset", int'(xfer_reset), 0);
    rd_reg(2'd2, v); check("R1 status", int'(v), 8'h00);

    // R4 arm gap search in read mode with irq enabled
    wr_reg(2'd1, 8'h84);
    wr_reg(2'd1, 8'hC4);
    strobes(40);
    rd_reg(2'd2, v); check("R4 no flag in gap", int'(v), 8'h00);
    check("R2 head after gap", int'(head_pos), 40);
    strobes(7);
    check("R5 no irq at 7 bits", int'(irq), 0);
    strobes(1);
    check("R5 irq byte1", int'(irq), 1);
    rd_reg(2'd3, v); check("R5 byte1 data", int'(v), 8'hA5);
    check("R12 data read keeps irq", int'(irq), 1);
    rd_reg(2'd2, v); check("R12 flag cleared by data read", int'(v), 8'h00);
    check("R12 status read clears irq", int'(irq), 0);
    strobes(8);
    rd_reg(2'd2, v); check("R5 flag byte2", int'(v), 8'h02);
    rd_reg(2'd3, v); check("R5 byte2 data", int'(v), 8'h3C);
    wr_reg(2'd1, 8'h44); // irq off, no new edge
    strobes(8);
    check("R5 irq disabled", int'(irq), 0);
    rd_reg(2'd3, v); check("R5 byte3 data", int'(v), 8'h01);

    // R6 check phase: byte taken without gap search, then search resumes
    wr_reg(2'd1, 8'h04);
    wr_reg(2'd1, 8'hD4);
    strobes(8);
    check("R6 irq on check byte", int'(irq), 1);
    rd_reg(2'd3, v); check("R6 check byte data", int'(v), 8'h5A);
    strobes(16);
    rd_reg(2'd2, v); check("R6 gap search resumed", int'(v), 8'h00);
    strobes(8);
    rd_reg(2'd3, v); check("R6 byte after gap", int'(v), 8'h96);
    check("R2 head 96", int'(head_pos), 96);

    // R11 skip mode, R13 motor pulse
    rd0 = n_rd; wr0 = n_wr;
    wr_reg(2'd1, 8'h06);
    check("R11 xfer_reset set", int'(xfer_reset), 1);
    strobes(8);
    check("R11 head advances", int'(head_pos), 104);
    check("R11 no reads", n_rd - rd0, 0);
    rd_reg(2'd2, v); check("R11 no flag", int'(v), 8'h00);
    wr_reg(2'd1, 8'h05);
    wr_reg(2'd1, 8'h04);
    check("R13 one motor pulse", n_motor, 1);
    check("R11 sticky", int'(xfer_reset), 1);
    go_home();
    check("R11 cleared by home", int'(xfer_reset), 0);
    check("R2 home", int'(head_pos), 0);

    // R7..R9 write path
    for (int i = 0; i < NBYTES; i++) mem[i] = 8'hFF;
    write_protect = 1'b0;
    wr_reg(2'd0, 8'h3A);
    rd_reg(2'd2, v); check("R12 writable status", int'(v), 8'h80);
    wr_reg(2'd1, 8'h80);
    strobes(8);
    check("R7 unarmed writes zero", int'(mem[0]), 8'h00);
    wr_reg(2'd1, 8'hC0);
    rd_reg(2'd2, v); check("R7 arm sets flag", int'(v), 8'h82);
    wr_reg(2'd0, 8'hC3);
    strobes(8);
    check("R8 irq on write byte", int'(irq), 1);
    check("R8 byte1 written", int'(mem[1]), 8'h3A);
    wr_reg(2'd0, 8'h5F);
    strobes(8);
    check("R8 byte2 reload", int'(mem[2]), 8'hC3);
    wr_reg(2'd1, 8'hD0);
    check("R12 ctrl write clears irq", int'(irq), 0);
    strobes(24);
    check("R9 byte3", int'(mem[3]), 8'h5F);
    check("R9 byte4 from shifter", int'(mem[4]), 8'h5F);
    check("R9 latch zeroed", int'(mem[5]), 8'h00);
    check("R3 head 48", int'(head_pos), 48);

    // R10 write protect
    write_protect = 1'b1;
    wr0 = n_wr;
    strobes(8);
    check("R10 no writes", n_wr - wr0, 0);
    check("R10 disk untouched", int'(mem[6]), 8'hFF);
    check("R10 head advances", int'(head_pos), 56);

    // R2 end of disk
    strobes(NBITS - 56);
    check("R2 at end", int'(at_end), 1);
    rd_reg(2'd2, v); check("R2 status end bit", int'(v[6]), 1);
    strobes(2);
    check("R2 stops at end", int'(head_pos), NBITS);
    go_home();
    rd_reg(2'd2, v); check("R2 end cleared", int'(v[6]), 0);

    finish_run();
  end

endmodule